// File: doc/BRIEF.md
# Push-Pull Linear Regulator Control Core

This block is the synchronous decision core of a digitally controlled linear supply. An external phase-comparison detector reports, once per trigger, whether the divided output voltage sits below, on, or above a reference. The controller turns that two-bit code into driver commands for a bank of push (pull-up) devices and a single pull (pull-down) device. When the output is on target it keeps the push devices in the state they already had.

A level selection picks one of six target voltages, 0.5 V to 1.0 V in 0.1 V steps. From the selected level the controller makes a one-hot select for the feedback divider tap, so that the detector always sees a voltage near its fixed reference. It also makes a cumulative enable mask over six push-device groups, so the available pull-up strength stays about the same at every level. Both outputs come from the same registered level, so they change together. A detector-enable input parks the output stage with push and pull both off.

Top module: `rpc_push_pull_ctl`

## Requirements
- R1: On a clock edge with `trig`=1 and `det_en`=1, error code `err_code`=2'b11 (bit 1 is the first detector bit, bit 0 the second; this code means output too low) gives, after that edge, `push_on`=1, `push_up`=1, `push_dn`=0, `pull_en`=0.
- R2: Under the same conditions, code 2'b00 (output too high) gives `push_on`=0, `push_up`=0, `push_dn`=1, `pull_en`=1. The pull enable is never 1 for any other code, and `pull_en` and `push_on` are never 1 together.
- R3: Under the same conditions, code 2'b01 (on target) gives `push_up`=0, `push_dn`=0, `pull_en`=0, and `push_on` keeps its value from before the edge.
- R4: Code 2'b10, which a detector timing violation can produce, is handled exactly as code 2'b01 (hold).
- R5: While `det_en`=1, a clock edge with `trig`=0 leaves every output unchanged.
- R6: A clock edge with `det_en`=0 gives `push_on`=0, `pull_en`=0, `push_up`=0, `push_dn`=1, whatever `trig` and `err_code` are.
- R7: `lvl_sel` encodes the target as 0..5 for 0.5 V..1.0 V. It is captured on every edge with `trig`=1, whatever `det_en` is. Codes 6 and 7 are ignored and the level stays as it was. `tap_sel` is one-hot with bit n set for level n, so 0.7 V (level 2) selects the third tap.
- R8: `grp_en` has its lowest level+1 bits set while `push_on`=1 and is all zero while `push_on`=0. It follows a level change on the same edge as `tap_sel`.
- R9: After synchronous reset, `push_on`, `pull_en`, `push_up`, `push_dn` and `grp_en` are 0, and the level is 0.5 V (`tap_sel`=6'b000001).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| det_en | input | 1 | Detector enable; low parks the output stage |
| trig | input | 1 | One-cycle pulse marking a valid detector decision |
| err_code | input | 2 | Detector result {first bit, second bit} |
| lvl_sel | input | 3 | Requested target level, 0 = 0.5 V .. 5 = 1.0 V |
| push_up | output | 1 | Command that turns the push devices on |
| push_dn | output | 1 | Command that turns the push devices off |
| push_on | output | 1 | Resulting push device state |
| grp_en | output | 6 | Per-group push enable, cumulative from group 0 |
| pull_en | output | 1 | Pull device enable |
| tap_sel | output | 6 | One-hot divider tap select |

## Verification
The hardest case to reach is a hold code, plain or the illegal 2'b10, that arrives right after a level change or a detector disable. Only there does the retained push state meet a new group mask, or a state that was forced off. A closed-loop plant model makes the bench drive the output voltage up to the target band on its own, so hold codes come up often. On top of that, random level changes, random disables and injected 2'b10 codes land on hold decisions after both push-on and push-off states.

// File: rtl/rpc_pkg.sv
package rpc_pkg;

    // Detector code values {first bit, second bit}
    localparam logic [1:0] ERR_LOW  = 2'b11;
    localparam logic [1:0] ERR_HIGH = 2'b00;
    localparam logic [1:0] ERR_ON   = 2'b01;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_RAISE = 2'd1,
        ACT_LOWER = 2'd2
    } act_e;

    typedef struct packed {
        logic push_on;
        logic up;
        logic dn;
        logic pull;
    } drv_s;

    localparam drv_s DRV_IDLE   = '{push_on: 1'b0, up: 1'b0, dn: 1'b0, pull: 1'b0};
    localparam drv_s DRV_PARKED = '{push_on: 1'b0, up: 1'b0, dn: 1'b1, pull: 1'b0};

    // Any code that is neither too-low nor too-high is a hold.
    function automatic act_e decode_err(input logic [1:0] code);
        act_e a;
        case (code)
            ERR_LOW:  a = ACT_RAISE;
            ERR_HIGH: a = ACT_LOWER;
            default:  a = ACT_HOLD;
        endcase
        return a;
    endfunction

    function automatic drv_s next_drv(input drv_s cur, input act_e a);
        drv_s n;
        case (a)
            ACT_RAISE: n = '{push_on: 1'b1, up: 1'b1, dn: 1'b0, pull: 1'b0};
            ACT_LOWER: n = '{push_on: 1'b0, up: 1'b0, dn: 1'b1, pull: 1'b1};
            default:   n = '{push_on: cur.push_on, up: 1'b0, dn: 1'b0, pull: 1'b0};
        endcase
        return n;
    endfunction

endpackage

// File: rtl/rpc_err_decode.sv
module rpc_err_decode
    import rpc_pkg::*;
(
    input  logic [1:0] err_code,
    output act_e       act
);
    always_comb begin
        act = decode_err(err_code);
    end
endmodule

// File: rtl/rpc_level_sel.sv
module rpc_level_sel #(
    parameter int LEVELS = 6,
    parameter int LVL_W  = $clog2(LEVELS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig,
    input  logic [LVL_W-1:0]  lvl_sel,
    output logic [LEVELS-1:0] tap_sel,
    output logic [LEVELS-1:0] grp_mask
);
    localparam logic [LVL_W:0] LVL_LIMIT = (LVL_W+1)'(LEVELS);

    logic [LVL_W-1:0] lvl_q;
    logic             lvl_ok;

    assign lvl_ok = ({1'b0, lvl_sel} < LVL_LIMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= '0;
        end else if (trig && lvl_ok) begin
            lvl_q <= lvl_sel;
        end
    end

    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        localparam logic [LVL_W-1:0] IDX = LVL_W'(g);
        assign tap_sel[g]  = (lvl_q == IDX);
        assign grp_mask[g] = (lvl_q >= IDX);
    end

    // R7
    tap_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(tap_sel) == 1);

    // R7
    tap_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (trig && lvl_ok) |=> tap_sel[$past(lvl_sel)]);

    // R7
    tap_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (!(trig && lvl_ok)) |=> $stable(tap_sel));

endmodule

// File: rtl/rpc_drive.sv
module rpc_drive
    import rpc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic det_en,
    input  logic trig,
    input  act_e act,
    output drv_s drv
);
    drv_s drv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_q <= DRV_IDLE;
        end else if (!det_en) begin
            drv_q <= DRV_PARKED;
        end else if (trig) begin
            drv_q <= next_drv(drv_q, act);
        end
    end

    assign drv = drv_q;

    // R2
    push_pull_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(drv_q.pull && drv_q.push_on));

    // R3
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (det_en && trig && act == ACT_HOLD) |=> ($stable(drv_q.push_on) && !drv_q.pull));

    // R5
    no_trig_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (det_en && !trig) |=> $stable(drv_q));

    // R6
    parked_chk: assert property (@(posedge clk) disable iff (rst)
        (!det_en) |=> (!drv_q.push_on && !drv_q.pull && drv_q.dn && !drv_q.up));

endmodule

// File: rtl/rpc_group_gate.sv
module rpc_group_gate #(
    parameter int GROUPS = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_on,
    input  logic [GROUPS-1:0] grp_mask,
    output logic [GROUPS-1:0] grp_en
);
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        assign grp_en[g] = grp_mask[g] & push_on;
    end

    // R8
    grp_contig_chk: assert property (@(posedge clk) disable iff (rst)
        (grp_en != '0) |-> (grp_en[0] && (((grp_en + 1'b1) & grp_en) == '0)));

    // R8
    grp_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!push_on) |-> (grp_en == '0));

endmodule

// File: rtl/rpc_push_pull_ctl.sv
module rpc_push_pull_ctl
    import rpc_pkg::*;
#(
    parameter int LEVELS = 6,
    parameter int LVL_W  = $clog2(LEVELS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              det_en,
    input  logic              trig,
    input  logic [1:0]        err_code,
    input  logic [LVL_W-1:0]  lvl_sel,
    output logic              push_up,
    output logic              push_dn,
    output logic              push_on,
    output logic [LEVELS-1:0] grp_en,
    output logic              pull_en,
    output logic [LEVELS-1:0] tap_sel
);
    act_e              act;
    drv_s              drv;
    logic [LEVELS-1:0] grp_mask;

    rpc_err_decode u_dec (
        .err_code (err_code),
        .act      (act)
    );

    rpc_level_sel #(.LEVELS(LEVELS), .LVL_W(LVL_W)) u_lvl (
        .clk      (clk),
        .rst      (rst),
        .trig     (trig),
        .lvl_sel  (lvl_sel),
        .tap_sel  (tap_sel),
        .grp_mask (grp_mask)
    );

    rpc_drive u_drv (
        .clk    (clk),
        .rst    (rst),
        .det_en (det_en),
        .trig   (trig),
        .act    (act),
        .drv    (drv)
    );

    rpc_group_gate #(.GROUPS(LEVELS)) u_grp (
        .clk      (clk),
        .rst      (rst),
        .push_on  (drv.push_on),
        .grp_mask (grp_mask),
        .grp_en   (grp_en)
    );

    assign push_on = drv.push_on;
    assign push_up = drv.up;
    assign push_dn = drv.dn;
    assign pull_en = drv.pull;

    // R1
    raise_chk: assert property (@(posedge clk) disable iff (rst)
        (det_en && trig && err_code == 2'b11) |=> (push_on && push_up && !push_dn && !pull_en));

    // R2
    lower_chk: assert property (@(posedge clk) disable iff (rst)
        (det_en && trig && err_code == 2'b00) |=> (!push_on && !push_up && push_dn && pull_en));

    // R4
    bad_code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (det_en && trig && err_code == 2'b10) |=> ($stable(push_on) && !push_up && !push_dn && !pull_en));

endmodule

// File: tb/tb_rpc_push_pull_ctl.sv
module tb_rpc_push_pull_ctl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       det_en = 1'b0;
    logic       trig = 1'b0;
    logic [1:0] err_code = 2'b01;
    logic [2:0] lvl_sel = 3'd0;
    logic       push_up, push_dn, push_on, pull_en;
    logic [5:0] grp_en, tap_sel;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // expected model state
    bit   e_on, e_up, e_dn, e_pull;
    int   e_lvl;
    int   vout_mv = 0;

    always #2.5 clk = ~clk;

    rpc_push_pull_ctl dut (
        .clk(clk), .rst(rst), .det_en(det_en), .trig(trig),
        .err_code(err_code), .lvl_sel(lvl_sel),
        .push_up(push_up), .push_dn(push_dn), .push_on(push_on),
        .grp_en(grp_en), .pull_en(pull_en), .tap_sel(tap_sel)
    );

    function automatic logic [5:0] exp_tap(int lvl);
        return 6'(1 << lvl);
    endfunction

    function automatic logic [5:0] exp_grp(int lvl, bit on);
        return on ? 6'((1 << (lvl + 1)) - 1) : 6'd0;
    endfunction

    task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        chk(req, "push_on", 8'(push_on), 8'(e_on));
        chk(req, "push_up", 8'(push_up), 8'(e_up));
        chk(req, "push_dn", 8'(push_dn), 8'(e_dn));
        chk(req, "pull_en", 8'(pull_en), 8'(e_pull));
        chk("R7", "tap_sel", 8'(tap_sel), 8'(exp_tap(e_lvl)));
        chk("R8", "grp_en", 8'(grp_en), 8'(exp_grp(e_lvl, e_on)));
    endtask

    // one clock: drive at negedge, model at posedge, check 1 ns later
    task automatic step(bit t, bit en, logic [1:0] code, logic [2:0] lvl, string req);
        @(negedge clk);
        trig = t; det_en = en; err_code = code; lvl_sel = lvl;
        @(posedge clk);
        if (t && lvl < 3'd6) e_lvl = int'(lvl);
        if (!en) begin
            e_on = 0; e_up = 0; e_dn = 1; e_pull = 0;
        end else if (t) begin
            case (code)
                2'b11: begin e_on = 1; e_up = 1; e_dn = 0; e_pull = 0; end
                2'b00: begin e_on = 0; e_up = 0; e_dn = 1; e_pull = 1; end
                default: begin e_up = 0; e_dn = 0; e_pull = 0; end
            endcase
        end
        #1;
        check_all(req);
    endtask

    function automatic logic [1:0] plant_code(int lvl);
        int tgt = 500 + 100 * lvl;
        if (vout_mv < tgt - 5) return 2'b11;
        if (vout_mv > tgt + 5) return 2'b00;
        return 2'b01;
    endfunction

    initial begin
        #1000000;
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        e_on = 0; e_up = 0; e_dn = 0; e_pull = 0; e_lvl = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check_all("R9");

        // directed corners
        step(1, 1, 2'b11, 3'd2, "R1");   // raise, 0.7 V -> third tap
        chk("R7", "tap third", 8'(tap_sel), 8'h04);
        step(0, 1, 2'b00, 3'd5, "R5");   // no trigger: nothing moves
        step(1, 1, 2'b01, 3'd5, "R3");   // hold keeps push on, level to 1.0 V
        chk("R8", "all groups", 8'(grp_en), 8'h3f);
        step(1, 1, 2'b10, 3'd7, "R4");   // illegal code and level ignored
        step(1, 1, 2'b00, 3'd6, "R2");
        step(1, 1, 2'b10, 3'd0, "R4");   // hold after off stays off
        step(1, 1, 2'b11, 3'd0, "R1");
        chk("R8", "one group", 8'(grp_en), 8'h01);
        step(1, 0, 2'b11, 3'd3, "R6");   // disabled: parked, level still taken
        step(1, 1, 2'b01, 3'd3, "R3");   // hold after park stays off
        step(0, 0, 2'b00, 3'd1, "R6");

        // closed loop with random disturbances
        for (int i = 0; i < 3000; i++) begin
            bit t, en;
            logic [1:0] c;
            logic [2:0] l;
            t  = ($urandom % 3) != 0;
            en = ($urandom % 20) != 0;
            c  = plant_code(e_lvl);
            if (($urandom % 10) == 0) c = 2'b10;
            l  = (($urandom % 25) == 0) ? 3'($urandom % 8) : 3'(e_lvl);
            case (c)
                2'b11: step(t, en, c, l, "R1");
                2'b00: step(t, en, c, l, "R2");
                2'b10: step(t, en, c, l, "R4");
                default: step(t, en, c, l, "R3");
            endcase
            if (push_on) vout_mv += 4 * $countones(grp_en);
            if (pull_en) vout_mv -= 15;
            vout_mv -= 2;
            if (vout_mv < 0) vout_mv = 0;
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule